// File: doc/BRIEF.md
# Serial Command and Readback Port for a Display Controller

This block is the host-facing port of a fluorescent display controller. A host drives a chip select, a serial clock and a single data line. While chip select is high, the host shifts a frame into the block one bit per rising serial-clock edge, least significant bit first. The last three bits of a frame carry a command code. When chip select drops, the block checks the code against the number of bits received. It then writes one or all three segment latches or the brightness latch, raises a one-cycle request to stop key scanning, or arms a readback.

A readback takes two chip-select windows. The first window carries only the 3-bit command. The next rising edge of chip select takes a snapshot of either the 29-bit switch word or the 48-bit converter word into the shift register and turns the data line around. Each rising serial-clock edge then moves the next bit onto the line. Dropping chip select releases the line, which ends the readback.

All three host pins are brought into the system clock domain through synchronizers. The serial clock must therefore be slow against the system clock: each serial-clock phase must last several system cycles.

Top module: `vfd_host_port`

## Requirements
- R1: After reset, all three segment latches and the brightness latch read 0, the data output enable and the data output are low, and no stop request is raised.
- R2: A 30-bit frame carries 27 payload bits followed by the command bits in the order c0, c1, c2. The code value is {c2,c1,c0}. The first payload bit lands in bit 0 of the latch. Code 0 writes the payload to all three segment latches.
- R3: Codes 1, 2 and 3 with a 30-bit frame write only segment latch 0, 1 or 2 respectively. The other latches keep their values.
- R4: Code 4 with a 13-bit frame writes its 10 payload bits, first bit as bit 0, to the brightness latch.
- R5: Latches change only after chip select falls. While chip select is still high after a complete frame, the outputs hold their old values.
- R6: A frame whose length does not match its code (30 bits for codes 0 to 3, 13 bits for code 4, 3 bits for codes 5 to 7) changes no latch and raises no stop request.
- R7: A 3-bit frame with code 5 raises the stop output for exactly one system clock cycle after chip select falls.
- R8: A 3-bit frame with code 6 arms a switch readback. On the next chip-select window, the output enable is high, and the data line presents switch-word bit 0 first and then the next bit after each rising serial-clock edge.
- R9: A 3-bit frame with code 7 arms a converter readback of 48 bits. Channel 1 is in word bits 7:0, channel 2 in bits 15:8, and so on up to channel 6 in bits 47:40. Bit 0 goes out first.
- R10: Chip select falling after a readback window drops the output enable. The request is used up, so the following chip-select window is a write window with the output enable low.
- R11: The readback word is a snapshot taken at the chip-select rising edge. Changes on the capture inputs during the window do not alter the shifted bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Host chip select, active high, asynchronous |
| sclk_i | input | 1 | Host serial clock, asynchronous |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |
| sdo_oe_o | output | 1 | High while the block drives the data line |
| grid0_seg_o | output | 27 | Segment latch for grid 0 |
| grid1_seg_o | output | 27 | Segment latch for grid 1 |
| grid2_seg_o | output | 27 | Segment latch for grid 2 |
| bright_o | output | 10 | Brightness latch |
| scan_stop_o | output | 1 | One-cycle request to stop key scanning |
| sw_word_i | input | 29 | Switch word to read back |
| adc_word_i | input | 48 | Six 8-bit converter results to read back |

## Verification
The bench checks the frames whose length does not match their code: a 29-bit segment frame, a 14-bit brightness frame, a 13-bit code-0 frame and a 4-bit stop frame. A decoder that checked only the code would corrupt a latch or fire a stop request on these frames. The bench also looks at the latches while chip select is still high after a full frame. A design that latched on the last bit instead of on chip-select fall would show the new value early. On readback, the bench changes the converter inputs in the middle of the shift, which would expose a design that reads the live inputs. It then opens a further window without a command, which would expose a design that leaves the readback request armed.

// File: rtl/vfd_host_port_pkg.sv
package vfd_host_port_pkg;

    localparam int CMD_BITS = 3;
    localparam int GRIDS    = 3;

    typedef enum logic [2:0] {
        CMD_ALL_GRIDS = 3'd0,
        CMD_GRID0     = 3'd1,
        CMD_GRID1     = 3'd2,
        CMD_GRID2     = 3'd3,
        CMD_BRIGHT    = 3'd4,
        CMD_STOP      = 3'd5,
        CMD_READ_SW   = 3'd6,
        CMD_READ_ADC  = 3'd7
    } cmd_code_e;

    typedef enum logic [1:0] {
        PORT_IDLE  = 2'd0,
        PORT_WRITE = 2'd1,
        PORT_READ  = 2'd2
    } port_state_e;

    typedef struct packed {
        logic [GRIDS-1:0] seg_we;
        logic             bright_we;
        logic             stop;
        logic             rd_sw;
        logic             rd_adc;
    } host_cmd_t;

    function automatic int expected_bits(cmd_code_e code, int seg_w, int bright_w);
        case (code)
            CMD_ALL_GRIDS, CMD_GRID0, CMD_GRID1, CMD_GRID2: return seg_w + CMD_BITS;
            CMD_BRIGHT:                                     return bright_w + CMD_BITS;
            default:                                        return CMD_BITS;
        endcase
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/vfd_pin_sync.sv
module vfd_pin_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/vfd_frame_decode.sv
module vfd_frame_decode
    import vfd_host_port_pkg::*;
#(
    parameter int SEG_W    = 27,
    parameter int BRIGHT_W = 10,
    parameter int CNT_W    = 6
) (
    input  logic [2:0]       code_bits,
    input  logic [CNT_W-1:0] bit_count,
    output host_cmd_t        cmd
);
    cmd_code_e code;
    logic      len_ok;

    always_comb begin
        code   = cmd_code_e'(code_bits);
        len_ok = (int'(bit_count) == expected_bits(code, SEG_W, BRIGHT_W));
        cmd    = '0;
        if (len_ok) begin
            case (code)
                CMD_ALL_GRIDS: cmd.seg_we    = '1;
                CMD_GRID0:     cmd.seg_we[0] = 1'b1;
                CMD_GRID1:     cmd.seg_we[1] = 1'b1;
                CMD_GRID2:     cmd.seg_we[2] = 1'b1;
                CMD_BRIGHT:    cmd.bright_we = 1'b1;
                CMD_STOP:      cmd.stop      = 1'b1;
                CMD_READ_SW:   cmd.rd_sw     = 1'b1;
                default:       cmd.rd_adc    = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/vfd_latch_bank.sv
module vfd_latch_bank
    import vfd_host_port_pkg::*;
#(
    parameter int SEG_W    = 27,
    parameter int BRIGHT_W = 10
) (
    input  logic                             clk,
    input  logic                             rst,
    input  host_cmd_t                        fire,
    input  logic [SEG_W-1:0]                 seg_data,
    input  logic [BRIGHT_W-1:0]              bright_data,
    output logic [GRIDS-1:0][SEG_W-1:0]      seg_q,
    output logic [BRIGHT_W-1:0]              bright_q
);
    for (genvar g = 0; g < GRIDS; g++) begin : g_grid
        always_ff @(posedge clk) begin
            if (rst)                 seg_q[g] <= '0;
            else if (fire.seg_we[g]) seg_q[g] <= seg_data;
        end

        assert_grid_hold_R3: assert property (@(posedge clk) disable iff (rst)
            !fire.seg_we[g] |=> $stable(seg_q[g]));
    end

    always_ff @(posedge clk) begin
        if (rst)                 bright_q <= '0;
        else if (fire.bright_we) bright_q <= bright_data;
    end

    assert_bright_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !fire.bright_we |=> $stable(bright_q));
endmodule

// File: rtl/vfd_host_port.sv
module vfd_host_port
    import vfd_host_port_pkg::*;
#(
    parameter int SEG_W       = 27,
    parameter int BRIGHT_W    = 10,
    parameter int SW_W        = 29,
    parameter int ADC_W       = 48,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_i,
    input  logic                sclk_i,
    input  logic                sdi_i,
    output logic                sdo_o,
    output logic                sdo_oe_o,
    output logic [SEG_W-1:0]    grid0_seg_o,
    output logic [SEG_W-1:0]    grid1_seg_o,
    output logic [SEG_W-1:0]    grid2_seg_o,
    output logic [BRIGHT_W-1:0] bright_o,
    output logic                scan_stop_o,
    input  logic [SW_W-1:0]     sw_word_i,
    input  logic [ADC_W-1:0]    adc_word_i
);
    localparam int SR_W    = max3(SEG_W + CMD_BITS, SW_W, ADC_W);
    localparam int CNT_W   = $clog2(SR_W + 2);
    localparam int CNT_SAT = SR_W + 1;

    logic [2:0] pins_q;
    logic       cs_q, sclk_q, sdi_q, cs_d, sclk_d;
    logic       cs_rise, cs_fall, sclk_rise;

    vfd_pin_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d({cs_i, sclk_i, sdi_i}), .q(pins_q)
    );
    assign {cs_q, sclk_q, sdi_q} = pins_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d   <= 1'b0;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_q;
            sclk_d <= sclk_q;
        end
    end

    assign cs_rise   = cs_q & ~cs_d;
    assign cs_fall   = ~cs_q & cs_d;
    assign sclk_rise = sclk_q & ~sclk_d & cs_q;

    port_state_e      state;
    logic [SR_W-1:0]  sr;
    logic [CNT_W-1:0] bit_cnt;
    logic             rd_armed, rd_is_adc;
    logic [SR_W-1:0]  sw_ext, adc_ext;

    always_comb begin
        sw_ext              = '0;
        sw_ext[SW_W-1:0]    = sw_word_i;
        adc_ext             = '0;
        adc_ext[ADC_W-1:0]  = adc_word_i;
    end

    // Newest bit enters at sr[0]; the code bits c2,c1,c0 sit at sr[0],sr[1],sr[2].
    logic [2:0]          code_bits;
    logic [SEG_W-1:0]    seg_payload;
    logic [BRIGHT_W-1:0] bright_payload;

    always_comb begin
        code_bits = {sr[0], sr[1], sr[2]};
        for (int j = 0; j < SEG_W; j++)    seg_payload[j]    = sr[SEG_W + CMD_BITS - 1 - j];
        for (int j = 0; j < BRIGHT_W; j++) bright_payload[j] = sr[BRIGHT_W + CMD_BITS - 1 - j];
    end

    host_cmd_t cmd, fire;

    vfd_frame_decode #(.SEG_W(SEG_W), .BRIGHT_W(BRIGHT_W), .CNT_W(CNT_W)) u_decode (
        .code_bits(code_bits), .bit_count(bit_cnt), .cmd(cmd)
    );

    assign fire = (cs_fall && state == PORT_WRITE) ? cmd : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PORT_IDLE;
            sr        <= '0;
            bit_cnt   <= '0;
            rd_armed  <= 1'b0;
            rd_is_adc <= 1'b0;
        end else if (cs_rise) begin
            bit_cnt <= '0;
            if (rd_armed) begin
                state <= PORT_READ;
                sr    <= rd_is_adc ? adc_ext : sw_ext;
            end else begin
                state <= PORT_WRITE;
                sr    <= '0;
            end
        end else if (cs_fall) begin
            state <= PORT_IDLE;
            if (state == PORT_READ) begin
                rd_armed <= 1'b0;
            end else if (fire.rd_sw || fire.rd_adc) begin
                rd_armed  <= 1'b1;
                rd_is_adc <= fire.rd_adc;
            end
        end else if (sclk_rise) begin
            if (state == PORT_WRITE) begin
                sr <= {sr[SR_W-2:0], sdi_q};
                if (int'(bit_cnt) < CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
            end else if (state == PORT_READ) begin
                sr <= {1'b0, sr[SR_W-1:1]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) scan_stop_o <= 1'b0;
        else     scan_stop_o <= fire.stop;
    end

    logic [GRIDS-1:0][SEG_W-1:0] seg_q;

    vfd_latch_bank #(.SEG_W(SEG_W), .BRIGHT_W(BRIGHT_W)) u_latches (
        .clk(clk), .rst(rst), .fire(fire), .seg_data(seg_payload),
        .bright_data(bright_payload), .seg_q(seg_q), .bright_q(bright_o)
    );

    assign grid0_seg_o = seg_q[0];
    assign grid1_seg_o = seg_q[1];
    assign grid2_seg_o = seg_q[2];
    assign sdo_oe_o    = (state == PORT_READ);
    assign sdo_o       = (state == PORT_READ) & sr[0];

    assert_oe_in_window_R10: assert property (@(posedge clk) disable iff (rst)
        sdo_oe_o |-> (cs_q || cs_d));
    assert_line_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe_o |-> !sdo_o);
    assert_stop_single_R7: assert property (@(posedge clk) disable iff (rst)
        scan_stop_o |=> !scan_stop_o);
    assert_one_action_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({|cmd.seg_we, cmd.bright_we, cmd.stop, cmd.rd_sw, cmd.rd_adc}));
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        int'(bit_cnt) <= CNT_SAT);
endmodule

// File: tb/vfd_host_port_test.sv
module vfd_host_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int NVEC       = 9;

    logic        clk = 1'b0, rst = 1'b1;
    logic        cs_i = 1'b0, sclk_i = 1'b0, sdi_i = 1'b0;
    logic        sdo_o, sdo_oe_o, scan_stop_o;
    logic [26:0] g0, g1, g2;
    logic [9:0]  bright;
    logic [28:0] sw_word_i = '0;
    logic [47:0] adc_word_i = '0;

    int checks = 0, errors = 0, stop_cnt = 0;
    logic [26:0] e0 = '0, e1 = '0, e2 = '0;
    logic [9:0]  eb = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vfd_host_port uut (
        .clk(clk), .rst(rst), .cs_i(cs_i), .sclk_i(sclk_i), .sdi_i(sdi_i),
        .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .grid0_seg_o(g0), .grid1_seg_o(g1),
        .grid2_seg_o(g2), .bright_o(bright), .scan_stop_o(scan_stop_o),
        .sw_word_i(sw_word_i), .adc_word_i(adc_word_i)
    );

    always @(posedge clk) if (!rst && scan_stop_o) stop_cnt++;

    // {code[2:0], length[5:0], payload[26:0]}
    localparam logic [35:0] VEC [NVEC] = '{
        {3'd0, 6'd30, 27'h5A5A5A5},
        {3'd1, 6'd30, 27'h0000001},
        {3'd2, 6'd30, 27'h4000000},
        {3'd3, 6'd30, 27'h1234567},
        {3'd4, 6'd13, 27'h00003FF},
        {3'd4, 6'd13, 27'h0000155},
        {3'd1, 6'd29, 27'h7FFFFFF},
        {3'd4, 6'd14, 27'h0002AAA},
        {3'd0, 6'd13, 27'h7FFFFFF}
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_latches(input string tag);
        check({tag, " grid0"}, 64'(g0), 64'(e0));
        check({tag, " grid1"}, 64'(g1), 64'(e1));
        check({tag, " grid2"}, 64'(g2), 64'(e2));
        check({tag, " bright"}, 64'(bright), 64'(eb));
    endtask

    task automatic open_frame(input logic [63:0] bits, input int n);
        cs_i = 1'b1;
        wait_clk(8);
        for (int i = 0; i < n; i++) begin
            sdi_i = bits[i];
            wait_clk(HALF);
            sclk_i = 1'b1;
            wait_clk(HALF);
            sclk_i = 1'b0;
        end
        wait_clk(8);
    endtask

    task automatic close_frame();
        cs_i = 1'b0;
        wait_clk(10);
    endtask

    function automatic logic [63:0] build(input logic [2:0] code, input int len, input logic [26:0] pay);
        logic [63:0] f;
        f = 64'(pay) & ((64'd1 << (len - 3)) - 64'd1);
        return f | (64'(code) << (len - 3));
    endfunction

    task automatic read_window(input logic [63:0] exp, input int n, input string tag, input bit scramble);
        int bad = 0;
        cs_i = 1'b1;
        wait_clk(8);
        check({tag, " oe during readback"}, 64'(sdo_oe_o), 64'd1);
        for (int i = 0; i < n; i++) begin
            if (sdo_o !== exp[i]) begin
                bad++;
                $display("FAIL %s bit %0d actual %0b expected %0b", tag, i, sdo_o, exp[i]);
            end
            if (scramble && i == 3) adc_word_i = ~adc_word_i;
            wait_clk(HALF);
            sclk_i = 1'b1;
            wait_clk(HALF);
            sclk_i = 1'b0;
        end
        checks++;
        if (bad != 0) errors++;
        cs_i = 1'b0;
        wait_clk(10);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(4);

        // R1: reset state
        check_latches("R1 reset");
        check("R1 oe", 64'(sdo_oe_o), 64'd0);
        check("R1 sdo", 64'(sdo_o), 64'd0);
        check("R1 stop", 64'(stop_cnt), 64'd0);

        // Table walk: R2, R3, R4 valid frames; R6 length mismatches
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0]  code = VEC[v][35:33];
            int          len  = int'(VEC[v][32:27]);
            logic [26:0] pay  = VEC[v][26:0];
            string       tag;
            bit          ok   = (code <= 3'd3) ? (len == 30) : (code == 3'd4 && len == 13);
            open_frame(build(code, len, pay), len);
            close_frame();
            if (!ok)             tag = "R6";
            else if (code == 0)  tag = "R2";
            else if (code <= 3)  tag = "R3";
            else                 tag = "R4";
            if (ok) begin
                case (code)
                    3'd0: begin e0 = pay; e1 = pay; e2 = pay; end
                    3'd1: e0 = pay;
                    3'd2: e1 = pay;
                    3'd3: e2 = pay;
                    default: eb = pay[9:0];
                endcase
            end
            check_latches(tag);
        end
        check("R6 no stop from table", 64'(stop_cnt), 64'd0);

        // R5: nothing latches until chip select falls
        open_frame(build(3'd2, 30, 27'h3C3C3C3), 30);
        check_latches("R5 before fall");
        close_frame();
        e1 = 27'h3C3C3C3;
        check_latches("R5 after fall");

        // R7: stop command gives exactly one pulse
        s0 = stop_cnt;
        open_frame(build(3'd5, 3, 27'd0), 3);
        close_frame();
        check("R7 stop pulse", 64'(stop_cnt - s0), 64'd1);
        check_latches("R7 latches kept");

        // R6: 4-bit frame with stop code is discarded
        s0 = stop_cnt;
        open_frame(build(3'd5, 4, 27'd1), 4);
        close_frame();
        check("R6 bad stop length", 64'(stop_cnt - s0), 64'd0);

        // R8: switch readback
        sw_word_i = 29'h1ABCDE5;
        open_frame(build(3'd6, 3, 27'd0), 3);
        close_frame();
        check("R8 oe off between windows", 64'(sdo_oe_o), 64'd0);
        read_window(64'(29'h1ABCDE5), 29, "R8 switch word", 1'b0);

        // R10: output released, request consumed
        check("R10 oe after fall", 64'(sdo_oe_o), 64'd0);
        cs_i = 1'b1;
        wait_clk(10);
        check("R10 next window is write", 64'(sdo_oe_o), 64'd0);
        close_frame();
        check_latches("R10 empty frame discarded");

        // R9 and R11: converter readback, inputs change mid-window
        adc_word_i = {8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11};
        open_frame(build(3'd7, 3, 27'd0), 3);
        close_frame();
        read_window({16'd0, 8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11}, 48,
                    "R9 R11 converter word", 1'b1);
        check("R10 oe after converter read", 64'(sdo_oe_o), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule